// File: doc/BRIEF.md
# Paged Audio Controller Register File

This block is the 32-bit register front end of a three-channel audio DMA controller: two playback channels and one record channel. A host reaches it through an 8-bit I/O offset with single-cycle write strobes and read strobes. Reads return data one cycle later with a valid flag. The block holds the control, status, page, codec and serial-control words and one sample-count word per channel. Offsets 0x30 through 0x3F form a paged window. There the 4-bit page register is placed above the offset to form a 12-bit internal address. That internal space holds each channel's frame address and frame count.

The DMA engines sit outside this block. They see every channel word through output ports and receive a one-cycle pulse telling them to drop their partial-word byte count when software rewrites a frame count. The engines report buffer completion through a per-channel event input. The block turns these events into pending bits, gated by the channel's interrupt enable. It ORs the pending bits into a summary status bit and the interrupt line.

Top module: `paged_audio_regs`

## Requirements
- R1: After reset, control reads 0x00000001 and status reads 0x00000060. Page, codec, serial control and all sample counts read 0. The interrupt line is low.
- R2: A read strobe returns its data on `rd_data` with `rd_valid` high exactly one cycle later.
- R3: A write to the page register (offset 0x0C) keeps only the low 4 bits. The page register reads back those 4 bits, zero-extended.
- R4: For offsets 0x30..0x3F the internal address is (page << 8) | offset. All other offsets ignore the page. The frame address and frame count of channel 0 (playback 1) are at internal 0xC30 and 0xC34. Those of channel 1 (playback 2) are at 0xC38 and 0xC3C. Those of channel 2 (record) are at 0xD30 and 0xD34.
- R5: Internal addresses 0xD38 and 0xD3C read 0xFFFFFFFF, and writes to them change no register.
- R6: Any offset or internal address with no register reads 0xFFFFFFFF, and writing there changes no register.
- R7: A write to a sample-count register (0x24 channel 0, 0x28 channel 1, 0x2C channel 2) stores the low 16 bits of the data in both halves of the word.
- R8: A frame-count write stores the full word. It also raises that channel's bit of `leftover_clr` (bit index = channel) for exactly the next cycle, and no other bit.
- R9: A channel event sets a pending bit only while that channel's enable bit is set. The enable bits are serial-control bit 8 for channel 0, bit 9 for channel 1 and bit 10 for channel 2. The pending bits are status bit 2 for channel 0, bit 1 for channel 1 and bit 0 for channel 2.
- R10: Status bit 31 and `irq` are high exactly when any pending bit is set.
- R11: A serial-control write that turns an enable bit from 1 to 0 clears that channel's pending bit. A write that leaves an enable bit set keeps the pending bit.
- R12: Writes to status are ignored. Control, codec and serial control read back the full word last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 8 | Register offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| chan_evt | input | 3 | Per-channel completion event (bit = channel) |
| irq | output | 1 | Interrupt line |
| ctrl_o | output | 32 | Control word |
| sctl_o | output | 32 | Serial-control word |
| scnt_o | output | 96 | Sample counts, channel i at bits 32i+31..32i |
| fadr_o | output | 96 | Frame addresses, same packing |
| fcnt_o | output | 96 | Frame counts, same packing |
| leftover_clr | output | 3 | Per-channel leftover-clear pulse |

## Verification
The bench goes after the paged window. It writes frame words under pages 0xC and 0xD and reads them back under each page. A decoder that ignored the page, or applied it outside 0x30..0x3F, would return another channel's word or all ones. It then writes to the phantom pair and to an empty page and checks every frame port. A decoder that aliased these addresses onto a real channel would corrupt a frame word. Interrupt checks fire events with enables off and on, then clear one enable while others stay set. A design that latched events regardless of enable, or cleared pending bits on every serial-control write, would show the wrong status bits or a stuck or missing `irq`.

// File: rtl/apc_pkg.sv
package apc_pkg;

   typedef enum logic [3:0] {
      K_NONE,
      K_CTRL,
      K_STAT,
      K_PAGE,
      K_CODEC,
      K_SCTL,
      K_SCNT,
      K_FADR,
      K_FCNT
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e   kind;
      logic [1:0]  ch;
   } reg_sel_t;

   // offsets that host software and the channel engines rely on
   localparam logic [7:0]  OFS_CTRL  = 8'h00;
   localparam logic [7:0]  OFS_STAT  = 8'h04;
   localparam logic [7:0]  OFS_PAGE  = 8'h0C;
   localparam logic [7:0]  OFS_CODEC = 8'h10;
   localparam logic [7:0]  OFS_SCTL  = 8'h20;
   localparam logic [7:0]  OFS_SCNT0 = 8'h24;
   localparam logic [7:0]  WIN_LO    = 8'h30;
   localparam logic [7:0]  WIN_HI    = 8'h3F;
   localparam logic [11:0] IA_PLAY   = 12'hC30;
   localparam logic [11:0] IA_REC    = 12'hD30;

   localparam int INTEN_LSB = 8;
   localparam logic [31:0] CTRL_RST = 32'h0000_0001;
   localparam logic [1:0]  STAT_FIXED = 2'b11;

endpackage

// File: rtl/apc_addr_map.sv
module apc_addr_map
   import apc_pkg::*;
#(
   parameter int AW = 8,
   parameter int PW = 4
) (
   input  logic [AW-1:0] addr,
   input  logic [PW-1:0] page,
   output reg_sel_t      sel
);
   localparam int IW = AW + PW;

   if (AW != 8)  begin : g_bad_aw $error("apc_addr_map: AW must be 8"); end
   if (PW != 4)  begin : g_bad_pw $error("apc_addr_map: PW must be 4"); end

   logic          in_win;
   logic [IW-1:0] iaddr;

   assign in_win = (addr >= WIN_LO) && (addr <= WIN_HI);
   assign iaddr  = in_win ? {page, addr} : {{PW{1'b0}}, addr};

   always_comb begin
      sel.kind = K_NONE;
      sel.ch   = 2'd0;
      case (iaddr)
         {4'h0, OFS_CTRL}:  sel.kind = K_CTRL;
         {4'h0, OFS_STAT}:  sel.kind = K_STAT;
         {4'h0, OFS_PAGE}:  sel.kind = K_PAGE;
         {4'h0, OFS_CODEC}: sel.kind = K_CODEC;
         {4'h0, OFS_SCTL}:  sel.kind = K_SCTL;
         {4'h0, OFS_SCNT0}:         begin sel.kind = K_SCNT; sel.ch = 2'd0; end
         {4'h0, OFS_SCNT0 + 8'h4}:  begin sel.kind = K_SCNT; sel.ch = 2'd1; end
         {4'h0, OFS_SCNT0 + 8'h8}:  begin sel.kind = K_SCNT; sel.ch = 2'd2; end
         IA_PLAY:           begin sel.kind = K_FADR; sel.ch = 2'd0; end
         IA_PLAY + 12'h4:   begin sel.kind = K_FCNT; sel.ch = 2'd0; end
         IA_PLAY + 12'h8:   begin sel.kind = K_FADR; sel.ch = 2'd1; end
         IA_PLAY + 12'hC:   begin sel.kind = K_FCNT; sel.ch = 2'd1; end
         IA_REC:            begin sel.kind = K_FADR; sel.ch = 2'd2; end
         IA_REC + 12'h4:    begin sel.kind = K_FCNT; sel.ch = 2'd2; end
         default:           sel.kind = K_NONE;   // includes the phantom pair
      endcase
   end
endmodule

// File: rtl/apc_chan_regs.sv
module apc_chan_regs #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_scnt,
   input  logic          wr_fadr,
   input  logic          wr_fcnt,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] scnt,
   output logic [DW-1:0] fadr,
   output logic [DW-1:0] fcnt,
   output logic          lc_clr
);
   localparam int HW = DW / 2;

   if (DW % 2 != 0) begin : g_bad_dw $error("apc_chan_regs: DW must be even"); end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scnt   <= '0;
         fadr   <= '0;
         fcnt   <= '0;
         lc_clr <= 1'b0;
      end else begin
         lc_clr <= wr_fcnt;
         if (wr_scnt) scnt <= {wdata[HW-1:0], wdata[HW-1:0]};
         if (wr_fadr) fadr <= wdata;
         if (wr_fcnt) fcnt <= wdata;
      end
   end

   p_scnt_halves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_scnt |=> (scnt[DW-1:HW] == scnt[HW-1:0]));
   p_lc_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lc_clr |-> $past(wr_fcnt));
endmodule

// File: rtl/apc_irq_status.sv
module apc_irq_status #(
   parameter int N_CH = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] evt,
   input  logic [N_CH-1:0] inten,
   input  logic            sctl_wr,
   input  logic [N_CH-1:0] new_inten,
   output logic [N_CH-1:0] pend,
   output logic            irq
);
   logic [N_CH-1:0] fall;

   assign fall = inten & ~new_inten & {N_CH{sctl_wr}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend | (evt & inten)) & ~fall;
   end

   assign irq = |pend;

   for (genvar i = 0; i < N_CH; i++) begin : g_chk
      p_set_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend[i]) |-> $past(inten[i]));
      p_clear_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend[i]) |-> $past(sctl_wr && !new_inten[i]));
   end
endmodule

// File: rtl/paged_audio_regs.sv
module paged_audio_regs
   import apc_pkg::*;
#(
   parameter int DW   = 32,
   parameter int AW   = 8,
   parameter int PW   = 4,
   parameter int N_CH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    rd_data,
   output logic             rd_valid,
   input  logic [N_CH-1:0]  chan_evt,
   output logic             irq,
   output logic [DW-1:0]    ctrl_o,
   output logic [DW-1:0]    sctl_o,
   output logic [N_CH*DW-1:0] scnt_o,
   output logic [N_CH*DW-1:0] fadr_o,
   output logic [N_CH*DW-1:0] fcnt_o,
   output logic [N_CH-1:0]  leftover_clr
);
   localparam int STAT_PAD = DW - 1 - 7;

   if (DW != 32)  begin : g_bad_dw  $error("paged_audio_regs: DW must be 32"); end
   if (N_CH != 3) begin : g_bad_nch $error("paged_audio_regs: N_CH must be 3"); end

   reg_sel_t        sel;
   logic [PW-1:0]   page_q;
   logic [DW-1:0]   ctrl_q, codec_q, sctl_q, status_w, rmux;
   logic [DW-1:0]   scnt_a [N_CH];
   logic [DW-1:0]   fadr_a [N_CH];
   logic [DW-1:0]   fcnt_a [N_CH];
   logic [N_CH-1:0] pend, pend_stat;
   logic            sctl_wr, sel_none, sel_stat, sel_page;

   apc_addr_map #(.AW(AW), .PW(PW)) u_map (
      .addr (addr),
      .page (page_q),
      .sel  (sel)
   );

   assign sctl_wr  = wr_en && (sel.kind == K_SCTL);
   assign sel_none = (sel.kind == K_NONE);
   assign sel_stat = (sel.kind == K_STAT);
   assign sel_page = (sel.kind == K_PAGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_RST;
         codec_q <= '0;
         sctl_q  <= '0;
         page_q  <= '0;
      end else if (wr_en) begin
         case (sel.kind)
            K_CTRL:  ctrl_q  <= wr_data;
            K_CODEC: codec_q <= wr_data;
            K_SCTL:  sctl_q  <= wr_data;
            K_PAGE:  page_q  <= wr_data[PW-1:0];
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      apc_chan_regs #(.DW(DW)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_scnt (wr_en && sel.kind == K_SCNT && sel.ch == 2'(i)),
         .wr_fadr (wr_en && sel.kind == K_FADR && sel.ch == 2'(i)),
         .wr_fcnt (wr_en && sel.kind == K_FCNT && sel.ch == 2'(i)),
         .wdata   (wr_data),
         .scnt    (scnt_a[i]),
         .fadr    (fadr_a[i]),
         .fcnt    (fcnt_a[i]),
         .lc_clr  (leftover_clr[i])
      );
      assign scnt_o[i*DW +: DW] = scnt_a[i];
      assign fadr_o[i*DW +: DW] = fadr_a[i];
      assign fcnt_o[i*DW +: DW] = fcnt_a[i];
      // channel 0 reports in the highest pending bit
      assign pend_stat[N_CH-1-i] = pend[i];
   end

   apc_irq_status #(.N_CH(N_CH)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (chan_evt),
      .inten     (sctl_q[INTEN_LSB +: N_CH]),
      .sctl_wr   (sctl_wr),
      .new_inten (wr_data[INTEN_LSB +: N_CH]),
      .pend      (pend),
      .irq       (irq)
   );

   assign status_w = {irq, {STAT_PAD{1'b0}}, STAT_FIXED, 2'b00, pend_stat};

   always_comb begin
      case (sel.kind)
         K_CTRL:  rmux = ctrl_q;
         K_STAT:  rmux = status_w;
         K_PAGE:  rmux = {{(DW-PW){1'b0}}, page_q};
         K_CODEC: rmux = codec_q;
         K_SCTL:  rmux = sctl_q;
         K_SCNT:  rmux = scnt_a[sel.ch];
         K_FADR:  rmux = fadr_a[sel.ch];
         K_FCNT:  rmux = fcnt_a[sel.ch];
         default: rmux = '1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= rmux;
      end
   end

   assign ctrl_o = ctrl_q;
   assign sctl_o = sctl_q;

   p_unmapped_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel_none) |=> (rd_valid && rd_data == '1));
   p_summary_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel_stat) |=> (rd_data[DW-1] == $past(irq)));
   p_page_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_page) |=> (page_q == $past(wr_data[PW-1:0])));
endmodule

// File: tb/paged_audio_regs_tb.sv
`timescale 1ns/1ps
module paged_audio_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic [2:0]  chan_evt = '0;
   logic        irq;
   logic [31:0] ctrl_o, sctl_o;
   logic [95:0] scnt_o, fadr_o, fcnt_o;
   logic [2:0]  leftover_clr;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   paged_audio_regs u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
      .chan_evt(chan_evt), .irq(irq), .ctrl_o(ctrl_o), .sctl_o(sctl_o),
      .scnt_o(scnt_o), .fadr_o(fadr_o), .fcnt_o(fcnt_o),
      .leftover_clr(leftover_clr)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      rd_en = 1'b1; addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic evt(input logic [2:0] m);
      @(posedge clk); #1;
      chan_evt = m;
      @(posedge clk); #1;
      chan_evt = '0;
   endtask

   // monitor: pops one expectation per returned read (R2)
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R2 unexpected read data actual=%h expected=none", rd_data);
         end else begin
            chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk({31'b0, irq}, 32'h0, "R1 irq after reset");
      rd(8'h00, 32'h0000_0001, "R1 control reset");
      rd(8'h04, 32'h0000_0060, "R1 status reset");
      rd(8'h0C, 32'h0, "R1 page reset");
      rd(8'h10, 32'h0, "R1 codec reset");
      rd(8'h20, 32'h0, "R1 serial control reset");
      rd(8'h2C, 32'h0, "R1 sample count reset");

      // R3 page masking
      wr(8'h0C, 32'hFFFF_FFFC);
      rd(8'h0C, 32'h0000_000C, "R3 page low bits");

      // R12 full-word registers and read-only status
      wr(8'h00, 32'hA5A5_0F0F);
      rd(8'h00, 32'hA5A5_0F0F, "R12 control readback");
      chk(ctrl_o, 32'hA5A5_0F0F, "R12 control port");
      wr(8'h10, 32'h1234_5678);
      rd(8'h10, 32'h1234_5678, "R12 codec readback");
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, 32'h0000_0060, "R12 status write ignored");

      // R7 sample-count replication
      wr(8'h28, 32'hABCD_1234);
      rd(8'h28, 32'h1234_1234, "R7 sample count ch1");
      chk(scnt_o[63:32], 32'h1234_1234, "R7 sample count port ch1");
      chk(scnt_o[31:0], 32'h0, "R7 ch0 untouched");

      // R4 / R8 paged frame registers, page 0xC already set
      wr(8'h30, 32'h1111_0000);
      wr(8'h34, 32'h0000_2222);
      chk({29'b0, leftover_clr}, 32'h1, "R8 leftover clear ch0");
      @(posedge clk); #1;
      chk({29'b0, leftover_clr}, 32'h0, "R8 pulse one cycle");
      wr(8'h38, 32'h0000_3333);
      wr(8'h3C, 32'h0000_4444);
      chk({29'b0, leftover_clr}, 32'h2, "R8 leftover clear ch1");
      wr(8'h0C, 32'h0000_000D);
      wr(8'h30, 32'h0000_5555);
      wr(8'h34, 32'h0000_6666);
      chk({29'b0, leftover_clr}, 32'h4, "R8 leftover clear ch2");
      chk(fcnt_o[95:64], 32'h0000_6666, "R8 frame count port ch2");

      // R5 phantom pair
      wr(8'h38, 32'hDEAD_BEEF);
      wr(8'h3C, 32'hDEAD_BEEF);
      chk({29'b0, leftover_clr}, 32'h0, "R5 phantom no leftover clear");
      rd(8'h38, 32'hFFFF_FFFF, "R5 phantom address read");
      rd(8'h3C, 32'hFFFF_FFFF, "R5 phantom count read");
      rd(8'h30, 32'h0000_5555, "R4 record frame address");
      rd(8'h34, 32'h0000_6666, "R4 record frame count");

      wr(8'h0C, 32'h0000_000C);
      rd(8'h30, 32'h1111_0000, "R4 play1 frame address");
      rd(8'h34, 32'h0000_2222, "R4 play1 frame count");
      rd(8'h3C, 32'h0000_4444, "R4 play2 frame count");
      rd(8'h24, 32'h0000_0000, "R4 outside window ignores page");

      // R6 empty page and unmapped offsets
      wr(8'h0C, 32'h0);
      rd(8'h30, 32'hFFFF_FFFF, "R6 empty page read");
      wr(8'h30, 32'h7777_7777);
      wr(8'h3C, 32'h7777_7777);
      chk(fadr_o[31:0],  32'h1111_0000, "R6 write ignored ch0 addr");
      chk(fcnt_o[63:32], 32'h0000_4444, "R6 write ignored ch1 count");
      chk(fadr_o[95:64], 32'h0000_5555, "R5 phantom write ignored ch2 addr");
      rd(8'h14, 32'hFFFF_FFFF, "R6 unmapped offset");

      // R9 events without enable
      evt(3'b111);
      chk({31'b0, irq}, 32'h0, "R9 no pend without enable");
      rd(8'h04, 32'h0000_0060, "R9 status without enable");

      // R9 / R10 with enables
      wr(8'h20, 32'h0000_0700);
      evt(3'b001);
      chk({31'b0, irq}, 32'h1, "R10 irq after ch0 event");
      rd(8'h04, 32'h8000_0064, "R9 ch0 pending bit2");
      evt(3'b100);
      rd(8'h04, 32'h8000_0065, "R9 ch2 pending bit0");

      // R11 enable fall clears only that channel
      wr(8'h20, 32'h0000_0600);
      rd(8'h04, 32'h8000_0061, "R11 clear ch0 pending");
      rd(8'h20, 32'h0000_0600, "R12 serial control readback");
      wr(8'h20, 32'h0000_0600);
      rd(8'h04, 32'h8000_0061, "R11 held enable keeps pending");
      wr(8'h20, 32'h0);
      rd(8'h04, 32'h0000_0060, "R10 summary low");
      chk({31'b0, irq}, 32'h0, "R10 irq low");

      repeat (3) @(posedge clk);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R2 missing read data actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule